// File: doc/BRIEF.md
# Two-Buffer Tile Ownership Sequencer

This block sequences tile traffic between a producer that writes tiles and a consumer that reads them, through a pair of staging buffers. It tracks who owns each buffer at every moment. The producer fills one buffer while the consumer drains the other, and the two sides then swap. The storage and the data movement sit outside the block. The sequencer only issues permissions and keeps the ownership bookkeeping.

Each buffer moves through four states: free, filling, full, draining. A buffer becomes full when the producer reports that its write has completed. That event is the completion flag the consumer waits on. A buffer becomes free again when the consumer reports that its read and writeback are finished. That event is the read-done flag the producer must see before it reuses the buffer.

Each side keeps its own one-bit buffer index, and that index toggles on the side's own done event. Two counters report how many tiles have been produced and how many have been consumed.

Top module: `dbuf_handshake`

## Requirements
- R1: After reset both buffers are free, `prod_idx` and `cons_idx` are 0, `prod_ready` is 1, `cons_ready` is 0, both busy outputs are 0 and both counters are 0.
- R2: A `prod_start` pulse while `prod_ready` is 1 sets `prod_busy` on the next cycle and marks the buffer at `prod_idx` as filling, so `prod_ready` drops.
- R3: A `prod_done` pulse while `prod_busy` is 1 marks that buffer full, clears `prod_busy`, toggles `prod_idx` and increments `prod_count`, all on the next cycle. If `cons_idx` points at that buffer and the consumer is idle, `cons_ready` is 1 from that same next cycle.
- R4: A `cons_latch` pulse is accepted only while `cons_ready` is 1. When accepted, it sets `cons_busy` on the next cycle and marks the buffer as draining.
- R5: A `cons_done` pulse while `cons_busy` is 1 frees the buffer, clears `cons_busy`, toggles `cons_idx` and increments `cons_count` on the next cycle.
- R6: The producer cannot start on a buffer that is full or draining. `prod_ready` stays 0 for that buffer, and a `prod_start` pulse leaves `prod_busy` at 0 until the consumer's done pulse frees the buffer.
- R7: Strobes that arrive out of turn have no effect: `prod_done` without `prod_busy`, `cons_latch` without `cons_ready`, and `cons_done` without `cons_busy` all leave every output unchanged.
- R8: The producer may fill one buffer while the consumer drains the other, and a start on one side and a latch on the other can both be accepted in the same cycle.
- R9: `prod_count - cons_count`, taken modulo 2^CNT_W, always lies between 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_start | input | 1 | Producer begins writing the buffer at `prod_idx` |
| prod_done | input | 1 | Producer's tile write has fully finished |
| prod_ready | output | 1 | Buffer at `prod_idx` is free and the producer is idle |
| prod_busy | output | 1 | Producer is filling a buffer |
| prod_idx | output | 1 | Buffer the producer targets |
| cons_latch | input | 1 | Consumer latches the buffer at `cons_idx` |
| cons_done | input | 1 | Consumer finished reading and writing back its result |
| cons_ready | output | 1 | Buffer at `cons_idx` is full and the consumer is idle |
| cons_busy | output | 1 | Consumer is draining a buffer |
| cons_idx | output | 1 | Buffer the consumer targets |
| prod_count | output | CNT_W | Tiles produced, wrapping |
| cons_count | output | CNT_W | Tiles consumed, wrapping |

## Verification
The hardest situation to reach from the ports is the one where both buffers are full or draining at once. In that state the producer has run a full lap ahead, and its start strobes must be refused until a read-done arrives. A directed sequence drives the producer through two complete fills while the consumer holds the first buffer. It then pulses start and latch out of turn before releasing the buffer. A long pseudo-random sweep then drives all sixteen combinations of the four strobes. That sweep repeatedly revisits the full-occupancy corner, same-cycle start and latch, and stray strobes, and a bench model built from the requirements predicts every output.

// File: rtl/dbuf_handshake.sv
module dbuf_handshake #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prod_start,
  input  logic             prod_done,
  output logic             prod_ready,
  output logic             prod_busy,
  output logic             prod_idx,
  input  logic             cons_latch,
  input  logic             cons_done,
  output logic             cons_ready,
  output logic             cons_busy,
  output logic             cons_idx,
  output logic [CNT_W-1:0] prod_count,
  output logic [CNT_W-1:0] cons_count
);

  localparam logic [1:0] S_FREE  = 2'd0;
  localparam logic [1:0] S_FILL  = 2'd1;
  localparam logic [1:0] S_FULL  = 2'd2;
  localparam logic [1:0] S_DRAIN = 2'd3;

  logic [1:0] bst [2];
  logic p_go, p_fin, c_go, c_fin;
  logic [CNT_W-1:0] occ;

  assign prod_ready = !prod_busy && (bst[prod_idx] == S_FREE);
  assign cons_ready = !cons_busy && (bst[cons_idx] == S_FULL);
  assign p_go  = prod_start && prod_ready;
  assign p_fin = prod_done  && prod_busy;
  assign c_go  = cons_latch && cons_ready;
  assign c_fin = cons_done  && cons_busy;
  assign occ   = prod_count - cons_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst[0]     <= S_FREE;
      bst[1]     <= S_FREE;
      prod_busy  <= 1'b0;
      cons_busy  <= 1'b0;
      prod_idx   <= 1'b0;
      cons_idx   <= 1'b0;
      prod_count <= '0;
      cons_count <= '0;
    end else begin
      if (p_go) begin
        prod_busy     <= 1'b1;
        bst[prod_idx] <= S_FILL;
      end
      if (p_fin) begin
        prod_busy     <= 1'b0;
        bst[prod_idx] <= S_FULL;
        prod_idx      <= ~prod_idx;
        prod_count    <= prod_count + 1'b1;
      end
      if (c_go) begin
        cons_busy     <= 1'b1;
        bst[cons_idx] <= S_DRAIN;
      end
      if (c_fin) begin
        cons_busy     <= 1'b0;
        bst[cons_idx] <= S_FREE;
        cons_idx      <= ~cons_idx;
        cons_count    <= cons_count + 1'b1;
      end
    end
  end

  assert_occupancy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(2));

  assert_no_shared_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_idx == cons_idx) |-> !(prod_ready && cons_ready));

  assert_prod_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_done && prod_busy) |=> (prod_idx != $past(prod_idx)) && !prod_busy);

  assert_cons_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_done && cons_busy) |=> (cons_idx != $past(cons_idx)) && !cons_busy);

  assert_latch_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_latch && !cons_ready && !cons_busy) |=> !cons_busy);

  assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_start && !prod_ready && !prod_busy) |=> !prod_busy);

endmodule

// File: tb/sim_dbuf_handshake.sv
module sim_dbuf_handshake;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0;
  logic ps = 0, pd = 0, cl = 0, cd = 0;
  logic prdy, pbusy, pidx, crdy, cbusy, cidx;
  logic [CW-1:0] pcnt, ccnt;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dbuf_handshake #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .prod_start(ps), .prod_done(pd), .prod_ready(prdy), .prod_busy(pbusy), .prod_idx(pidx),
    .cons_latch(cl), .cons_done(cd), .cons_ready(crdy), .cons_busy(cbusy), .cons_idx(cidx),
    .prod_count(pcnt), .cons_count(ccnt));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit a, bit b, bit c, bit d);
    ps = a; pd = b; cl = c; cd = d;
    @(posedge clk);
    @(negedge clk);
    ps = 0; pd = 0; cl = 0; cd = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    @(posedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  int mst[2];
  bit mpi, mci, mpb, mcb;
  int mpc, mcc;

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 prod_ready", prdy, 1); chk("R1 cons_ready", crdy, 0);
    chk("R1 prod_idx", pidx, 0);   chk("R1 cons_idx", cidx, 0);
    chk("R1 prod_busy", pbusy, 0); chk("R1 cons_busy", cbusy, 0);
    chk("R1 prod_count", pcnt, 0); chk("R1 cons_count", ccnt, 0);

    step(1,0,0,0); // R2
    chk("R2 prod_busy", pbusy, 1); chk("R2 prod_ready", prdy, 0); chk("R2 cons_ready", crdy, 0);
    step(0,1,0,0); // R3
    chk("R3 prod_idx", pidx, 1); chk("R3 prod_count", pcnt, 1);
    chk("R3 cons_ready next cycle", crdy, 1); chk("R3 prod_ready other buf", prdy, 1);
    step(1,0,1,0); // R8 latch and start same cycle
    chk("R8 cons_busy", cbusy, 1); chk("R8 prod_busy", pbusy, 1);
    step(0,1,0,0);
    chk("R6 prod_idx", pidx, 0); chk("R6 prod_ready blocked", prdy, 0);
    chk("R9 occupancy two", int'(pcnt - ccnt), 2);
    step(1,0,1,0); // R6 start refused, R7 latch ignored while busy
    chk("R6 start refused", pbusy, 0); chk("R7 cons_busy held", cbusy, 1);
    chk("R7 cons_idx held", cidx, 0);
    step(0,0,0,1); // R5
    chk("R5 cons_idx", cidx, 1); chk("R5 cons_count", ccnt, 1);
    chk("R5 prod_ready freed", prdy, 1); chk("R5 cons_ready next", crdy, 1);
    chk("R5 cons_busy", cbusy, 0);
    step(0,1,0,0); // R7 stray done
    chk("R7 prod_count held", pcnt, 2); chk("R7 prod_idx held", pidx, 0);
    step(0,0,0,1);
    chk("R7 cons_count held", ccnt, 1);

    do_reset();
    mst = '{0, 0}; mpi = 0; mci = 0; mpb = 0; mcb = 0; mpc = 0; mcc = 0;
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
        bit e_prdy, e_crdy, a, b, c, d;
        e_prdy = !mpb && mst[mpi] == 0;
        e_crdy = !mcb && mst[mci] == 2;
        chk("R2 sweep prod_ready", prdy, e_prdy);
        chk("R4 sweep cons_ready", crdy, e_crdy);
        chk("R2 sweep prod_busy", pbusy, mpb);
        chk("R4 sweep cons_busy", cbusy, mcb);
        chk("R3 sweep prod_idx", pidx, mpi);
        chk("R5 sweep cons_idx", cidx, mci);
        chk("R3 sweep prod_count", pcnt, mpc % 256);
        chk("R5 sweep cons_count", ccnt, mcc % 256);
        chk("R9 sweep occupancy", int'(CW'(pcnt - ccnt)) <= 2, 1);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        a = lf[0]; b = lf[3]; c = lf[6]; d = lf[9];
        if (a && e_prdy) begin mpb = 1; mst[mpi] = 1; end
        else if (b && mpb) begin mpb = 0; mst[mpi] = 2; mpi = !mpi; mpc++; end
        if (c && e_crdy) begin mcb = 1; mst[mci] = 3; end
        else if (d && mcb) begin mcb = 0; mst[mci] = 0; mci = !mci; mcc++; end
        step(a, b, c, d);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule